// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that software can read and write over a simple bus. The counter advances on one of two event sources. The first is the instruction-cycle strobe, which gives timer mode. The second is a chosen edge of an external input, which gives counter mode. The external input is first brought into the clock domain through a flop synchronizer, and an edge detector then turns each selected edge into a one-clock pulse. A single programmable prescaler sits in one of two places. It can divide the counter's events, or it can divide the instruction strobe for a watchdog path, whose tick leaves the block on its own output. When the prescaler belongs to the watchdog, the counter takes every event undivided.

When the counter wraps from its all-ones value to zero it sets a sticky overflow flag. The flag drives an interrupt output only while the interrupt enable input is high. A write to the counter throws away the events of the next two instruction cycles. While the sleep input is high, the counter takes no events at all.

Top module: `tmr8_presc`

## Requirements
- R1: After reset the count is 00h, the overflow flag is 0, and the control register reads 08h. That value means timer mode, rising edge, prescaler on the watchdog path, and ratio field 0.
- R2: A count write loads `wdata_i` and the new value appears on `cnt_o` one clock later. A control write stores `wdata_i[5:0]`, and `ctl_o` shows the stored value.
- R3: In timer mode (control bit 5 = 0) with the prescaler on the watchdog path (bit 3 = 1), the count rises by one on each instruction strobe.
- R4: In counter mode (bit 5 = 1) the count follows edges of `ext_clk_i`. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The count changes on the third rising clock edge after the input changes.
- R5: With bit 3 = 0 the counter advances once every 2^(r+1) events, where r is control bits 2:0. So 000 divides by 2 and 111 divides by 256.
- R6: After a count write, the events of the next two instruction strobes are discarded. When bit 3 = 0, the write also clears the prescaler. A control write that changes bit 3 clears the prescaler as well.
- R7: A wrap from FFh to 00h sets the overflow flag. The flag stays set until `flag_clr_i`. If a set and a clear fall in the same cycle, the set wins. `irq_o` is high exactly when the flag and `irq_en_i` are both high.
- R8: While `sleep_i` is high the count does not change.
- R9: With bit 3 = 1, `wdt_tick_o` pulses once every 2^(r+1) instruction strobes. With bit 3 = 0 it pulses on every instruction strobe.
- R10: A count write in the same cycle as a counting event loads the written value and does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb_i | input | 1 | One-clock strobe per instruction cycle |
| sleep_i | input | 1 | Stops the counter from taking events |
| ext_clk_i | input | 1 | External count input, asynchronous |
| cnt_wr_i | input | 1 | Count write strobe |
| ctl_wr_i | input | 1 | Control write strobe |
| wdata_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Clears the overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_o | output | 8 | Current count |
| ctl_o | output | 6 | Control register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Masked interrupt |
| wdt_tick_o | output | 1 | Watchdog-path tick |

## Verification
The hardest case to reach from the ports is the prescaler phase. The prescaler cannot be read, so a divided count only shows up after many events, and any residue left by an earlier test shifts every result after it. The stimulus therefore starts each vector with a control write, which reassigns the prescaler, and a count write, which clears it. It then issues a strobe count that covers the two discarded cycles plus whole multiples of the ratio. Runs long enough to fill the 1:256 setting are included. The edge latency of the external input is measured clock by clock after a single transition.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   localparam int CTL_W = 6;

   typedef struct packed {
      logic       src_ext;   // bit 5
      logic       fall_sel;  // bit 4
      logic       psa_wdt;   // bit 3
      logic [2:0] ratio;     // bits 2:0
   } ctl_t;

   localparam ctl_t CTL_RESET = '{src_ext: 1'b0, fall_sel: 1'b0, psa_wdt: 1'b1, ratio: 3'd0};
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fall_sel,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr8_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];

   always_comb begin
      if (fall_sel) pulse = last_q & ~sync_q[STAGES-1];
      else          pulse = sync_q[STAGES-1] & ~last_q;
   end
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
   parameter int PS_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       inc,
   input  logic [2:0] ratio,
   output logic       tick
);
   if (PS_W < 8) begin : g_bad_width
      $error("tmr8_prescaler: PS_W must cover the 1:256 ratio");
   end

   localparam logic [PS_W-1:0] ALL_ONES = {PS_W{1'b1}};

   logic [PS_W-1:0] pre_q;
   logic [PS_W-1:0] mask;

   assign mask = ALL_ONES >> (PS_W - 1 - int'(ratio));
   assign tick = inc && !clr && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (inc) pre_q <= pre_q + 1'b1;
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
   parameter int CNT_W     = 8,
   parameter int INHIB_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_stb,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             tick,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_flag,
   output logic             hold
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt <= '0;
      else if (wr)   cnt <= wdata;
      else if (tick) cnt <= cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            ovf_flag <= 1'b0;
      else if (tick && !wr && cnt == CNT_MAX) ovf_flag <= 1'b1;
      else if (flag_clr)                     ovf_flag <= 1'b0;

   if (INHIB_CYC == 0) begin : g_no_inhib
      assign hold = 1'b0;
   end else begin : g_inhib
      localparam int IW = $clog2(INHIB_CYC + 1);
      logic [IW-1:0] inhib_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                             inhib_q <= '0;
         else if (wr)                            inhib_q <= IW'(INHIB_CYC);
         else if (cyc_stb && inhib_q != '0)      inhib_q <= inhib_q - 1'b1;
      assign hold = (inhib_q != '0);
   end
endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc
   import tmr8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PS_W        = 8,
   parameter int SYNC_STAGES = 2,
   parameter int INHIB_CYC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_stb_i,
   input  logic             sleep_i,
   input  logic             ext_clk_i,
   input  logic             cnt_wr_i,
   input  logic             ctl_wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             flag_clr_i,
   input  logic             irq_en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CTL_W-1:0] ctl_o,
   output logic             ovf_flag_o,
   output logic             irq_o,
   output logic             wdt_tick_o
);
   if (CNT_W < CTL_W) begin : g_bad_cnt
      $error("tmr8_presc: CNT_W must hold the control field");
   end

   ctl_t ctl_q;
   ctl_t ctl_new;
   logic ext_pulse, src_evt, tmr_evt, hold;
   logic pre_inc, pre_clr, pre_tick, cnt_tick;

   if (CNT_W > CTL_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wdata_i[CNT_W-1:CTL_W];
   end

   assign ctl_new = ctl_t'(wdata_i[CTL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        ctl_q <= CTL_RESET;
      else if (ctl_wr_i) ctl_q <= ctl_new;

   tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (ext_clk_i),
      .fall_sel(ctl_q.fall_sel),
      .pulse   (ext_pulse)
   );

   assign src_evt  = ctl_q.src_ext ? ext_pulse : cyc_stb_i;
   assign tmr_evt  = src_evt && !sleep_i && !hold;
   assign pre_inc  = ctl_q.psa_wdt ? cyc_stb_i : tmr_evt;
   assign pre_clr  = (ctl_wr_i && (ctl_new.psa_wdt != ctl_q.psa_wdt))
                   || (cnt_wr_i && !ctl_q.psa_wdt);

   tmr8_prescaler #(.PS_W(PS_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pre_clr),
      .inc  (pre_inc),
      .ratio(ctl_q.ratio),
      .tick (pre_tick)
   );

   assign cnt_tick   = ctl_q.psa_wdt ? tmr_evt : pre_tick;
   assign wdt_tick_o = ctl_q.psa_wdt ? pre_tick : cyc_stb_i;

   tmr8_count #(.CNT_W(CNT_W), .INHIB_CYC(INHIB_CYC)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_stb (cyc_stb_i),
      .wr      (cnt_wr_i),
      .wdata   (wdata_i),
      .tick    (cnt_tick),
      .flag_clr(flag_clr_i),
      .cnt     (cnt_o),
      .ovf_flag(ovf_flag_o),
      .hold    (hold)
   );

   assign ctl_o = ctl_q;
   assign irq_o = ovf_flag_o & irq_en_i;
endmodule

// File: rtl/tmr8_presc_chk.sv
module tmr8_presc_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_i,
   input logic             cnt_wr_i,
   input logic [CNT_W-1:0] wdata_i,
   input logic             flag_clr_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic             ovf_flag_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> cnt_o == $past(wdata_i)); // R2

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)); // R3

   AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == CMAX && !cnt_wr_i) ##1 (cnt_o == '0) |-> ovf_flag_o); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o); // R7

   AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !cnt_wr_i) |=> $stable(cnt_o)); // R8
endmodule

bind tmr8_presc tmr8_presc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_i   (sleep_i),
   .cnt_wr_i  (cnt_wr_i),
   .wdata_i   (wdata_i),
   .flag_clr_i(flag_clr_i),
   .cnt_o     (cnt_o),
   .ovf_flag_o(ovf_flag_o)
);

// File: tb/tmr8_presc_bench.sv
module tmr8_presc_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_stb = 1'b0, sleep = 1'b0, ext = 1'b0;
   logic       cnt_wr = 1'b0, ctl_wr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] cnt;
   logic [5:0] ctl;
   logic       flag, irq, wdt_tick;
   int         n_chk = 0, n_fail = 0, wdt_cnt = 0;

   always #4 clk = ~clk;

   tmr8_presc u_tmr8_presc (
      .clk(clk), .rst_n(rst_n), .cyc_stb_i(cyc_stb), .sleep_i(sleep),
      .ext_clk_i(ext), .cnt_wr_i(cnt_wr), .ctl_wr_i(ctl_wr), .wdata_i(wdata),
      .flag_clr_i(flag_clr), .irq_en_i(irq_en), .cnt_o(cnt), .ctl_o(ctl),
      .ovf_flag_o(flag), .irq_o(irq), .wdt_tick_o(wdt_tick)
   );

   always @(posedge clk) if (wdt_tick) wdt_cnt <= wdt_cnt + 1;

   typedef struct packed {
      logic [7:0]  ctl;
      logic [15:0] n;
      logic [7:0]  exp;
   } vec_t;

   localparam vec_t VEC[5] = '{
      '{8'h08, 16'd10,  8'd8},   // R3 undivided
      '{8'h00, 16'd10,  8'd4},   // R5 1:2
      '{8'h01, 16'd18,  8'd4},   // R5 1:4
      '{8'h02, 16'd31,  8'd3},   // R5 1:8
      '{8'h07, 16'd514, 8'd2}    // R5 1:256
   };

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      cnt_wr = 1'b1; wdata = v;
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         cyc_stb = 1'b1;
         @(negedge clk);
         cyc_stb = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 count", cnt, 8'h00);
      chk("R1 flag", flag, 0);
      chk("R1 ctl", ctl, 6'h08);
      rst_n = 1'b1;
      @(negedge clk);

      wr_cnt(8'h5A);
      chk("R2 count load", cnt, 8'h5A);
      wr_ctl(8'h15);
      chk("R2 ctl readback", ctl, 6'h15);

      for (int v = 0; v < 5; v++) begin
         wr_ctl(VEC[v].ctl);
         wr_cnt(8'h00);
         strobe(int'(VEC[v].n));
         chk("R3/R5 vector", cnt, VEC[v].exp);
      end

      // R6 two discarded strobes
      wr_ctl(8'h08);
      wr_cnt(8'h10);
      strobe(1); chk("R6 first inhibited", cnt, 8'h10);
      strobe(1); chk("R6 second inhibited", cnt, 8'h10);
      strobe(1); chk("R6 resumes", cnt, 8'h11);

      // R4 rising edges and latency
      wr_ctl(8'h28);
      wr_cnt(8'h00);
      strobe(2);
      ext = 1'b1;
      repeat (2) @(negedge clk); chk("R4 latency before", cnt, 0);
      @(negedge clk);            chk("R4 latency third edge", cnt, 1);
      repeat (3) @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         ext = 1'b0; repeat (5) @(negedge clk);
         ext = 1'b1; repeat (5) @(negedge clk);
      end
      chk("R4 rising count", cnt, 3);
      ext = 1'b0; repeat (5) @(negedge clk);

      // R4 falling edges
      wr_ctl(8'h38);
      wr_cnt(8'h00);
      strobe(2);
      ext = 1'b1; repeat (6) @(negedge clk);
      chk("R4 rise ignored", cnt, 0);
      ext = 1'b0; repeat (6) @(negedge clk);
      chk("R4 fall counted", cnt, 1);

      // R7 overflow, mask, sticky, clear
      wr_ctl(8'h08);
      wr_cnt(8'hFE);
      strobe(3);
      chk("R7 at FF", cnt, 8'hFF);
      chk("R7 no flag yet", flag, 0);
      strobe(1);
      chk("R7 wrapped", cnt, 8'h00);
      chk("R7 flag set", flag, 1);
      chk("R7 irq masked", irq, 0);
      irq_en = 1'b1; @(negedge clk);
      chk("R7 irq enabled", irq, 1);
      strobe(2);
      chk("R7 flag sticky", flag, 1);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk("R7 flag cleared", flag, 0);
      chk("R7 irq cleared", irq, 0);
      wr_cnt(8'hFF);
      strobe(2);
      cyc_stb = 1'b1; flag_clr = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0; flag_clr = 1'b0;
      chk("R7 set beats clear", flag, 1);
      irq_en = 1'b0;
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

      // R10 write collides with an event
      wr_cnt(8'hFF);
      strobe(2);
      cyc_stb = 1'b1; cnt_wr = 1'b1; wdata = 8'h33;
      @(negedge clk);
      cyc_stb = 1'b0; cnt_wr = 1'b0;
      chk("R10 write wins", cnt, 8'h33);
      chk("R10 no flag", flag, 0);

      // R8 sleep
      wr_cnt(8'h20);
      strobe(2);
      sleep = 1'b1;
      strobe(5);
      chk("R8 frozen in sleep", cnt, 8'h20);
      sleep = 1'b0;
      strobe(1);
      chk("R8 resumes", cnt, 8'h21);

      // R9 watchdog tick
      wr_ctl(8'h00);
      wr_ctl(8'h09);
      wdt_cnt = 0;
      strobe(16);
      chk("R9 prescaled wdt tick", wdt_cnt, 4);
      wr_ctl(8'h00);
      wdt_cnt = 0;
      strobe(5);
      chk("R9 direct wdt tick", wdt_cnt, 5);

      finish_run();
   end
endmodule